// File: doc/BRIEF.md
# Presettable Synchronous Counter with Lookahead Carry

This block is a wide binary up-counter built from a chain of identical 4-bit stages. Each stage changes state only on the rising clock edge and obeys a fixed priority: a synchronous clear, then a synchronous parallel load, then a count step, and otherwise a hold. Clear and load are both active low.

Each stage has two count enables. The gate enable only permits counting. The chain enable also permits counting, and it also qualifies the stage's terminal-count output. That output is a purely combinational decode of "digit at its maximum and chain enable high". The wrapper feeds each stage's terminal count into the chain enable of the next stage. The carry therefore looks ahead through the chain within one cycle, and no stage waits on a registered ripple. The gate enable of every stage is tied to one shared input. The chain enable of the first stage comes from a separate input. The wrapper exposes the full count and the final carry.

Top module: `sync_preset_counter`

## Requirements
- R1: The count changes only at a rising clock edge. Input changes between edges leave `count` unchanged until the next rising edge.
- R2: When `clear_n` is 0 at a rising edge, `count` becomes 0. This happens whatever `load_n`, `gate_en`, `chain_en` and `din` are. `carry_out` is then 0.
- R3: When `clear_n` is 1 and `load_n` is 0 at a rising edge, `count` takes the value of `din`. This happens whatever the enables are.
- R4: When `clear_n` and `load_n` are both 1, and `gate_en` and `chain_en` are both 1, `count` increases by one at the rising edge, modulo 2^WIDTH. The all-ones value wraps to 0.
- R5: When `clear_n` and `load_n` are both 1 and either enable is 0, `count` holds its value.
- R6: `carry_out` is 1 exactly when `count` is all ones and `chain_en` is 1. `gate_en` has no effect on it.
- R7: Stage k counts only when every lower stage is at 15 and `chain_en` is 1. The chained counter therefore follows a plain integer counter through full wrap-around.
- R8: `carry_out` is combinational. It follows a change of `chain_en` within the same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| clear_n | input | 1 | Synchronous clear, active low, highest priority |
| load_n | input | 1 | Synchronous parallel load, active low |
| gate_en | input | 1 | Count enable shared by all stages; does not affect carry |
| chain_en | input | 1 | Count enable of the first stage; also qualifies carry |
| din | input | 4*STAGES | Parallel load data |
| count | output | 4*STAGES | Current count value |
| carry_out | output | 1 | Terminal count of the last stage |

## Verification
An uninterrupted count of more than 2^WIDTH cycles with both enables high walks the counter through every value. It shows that the lookahead carry advances the upper stage at the right edge and that the all-ones value wraps to zero. Directed cycles then combine a low clear with a low load and both enables high, and a low load with both enables low, and they drop each enable on its own. These cycles separate the four priority levels and show that each enable is needed for counting. At the all-ones value, `gate_en` and `chain_en` are toggled without a clock. This shows that carry follows only the chain enable and does so combinationally. A long pseudo-random stretch of mixed controls is compared with an integer model on every edge.

// File: rtl/cnt_pkg.sv
package cnt_pkg;
    localparam int DIGIT_W = 4;

    typedef enum logic [1:0] {
        OP_CLEAR = 2'd0,
        OP_LOAD  = 2'd1,
        OP_COUNT = 2'd2,
        OP_HOLD  = 2'd3
    } digit_op_e;

    typedef struct packed {
        logic [DIGIT_W-1:0] cnt;
    } digit_state_t;
endpackage

// File: rtl/cnt_tc_decode.sv
module cnt_tc_decode
    import cnt_pkg::*;
(
    input  logic [DIGIT_W-1:0] value,
    input  logic               chain_in,
    output logic               tc
);
    localparam logic [DIGIT_W-1:0] TOP_VAL = {DIGIT_W{1'b1}};

    always_comb begin
        tc = chain_in && (value == TOP_VAL);
    end
endmodule

// File: rtl/cnt_digit.sv
module cnt_digit
    import cnt_pkg::*;
(
    input  logic               clk,
    input  logic               clear_n,
    input  logic               load_n,
    input  logic               gate_in,
    input  logic               chain_in,
    input  logic [DIGIT_W-1:0] d,
    output logic [DIGIT_W-1:0] q,
    output logic               tc
);
    digit_state_t state_d, state_q;
    digit_op_e    op;

    always_comb begin
        if (!clear_n)                 op = OP_CLEAR;
        else if (!load_n)             op = OP_LOAD;
        else if (gate_in && chain_in) op = OP_COUNT;
        else                          op = OP_HOLD;

        state_d = state_q;
        unique case (op)
            OP_CLEAR: state_d.cnt = '0;
            OP_LOAD:  state_d.cnt = d;
            OP_COUNT: state_d.cnt = state_q.cnt + DIGIT_W'(1);
            default:  state_d.cnt = state_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    assign q = state_q.cnt;

    cnt_tc_decode u_tc (
        .value    (state_q.cnt),
        .chain_in (chain_in),
        .tc       (tc)
    );

    // R2: clear overrides everything
    p_clear_r2: assert property (@(posedge clk)
        !clear_n |=> (q == '0));

    // R3: load takes data regardless of enables
    p_load_r3: assert property (@(posedge clk) disable iff (!clear_n)
        (clear_n && !load_n) |=> (q == $past(d)));

    // R4: count step
    p_count_r4: assert property (@(posedge clk) disable iff (!clear_n)
        (clear_n && load_n && gate_in && chain_in) |=> (q == $past(q) + DIGIT_W'(1)));

    // R5: hold when an enable is low
    p_hold_r5: assert property (@(posedge clk) disable iff (!clear_n)
        (clear_n && load_n && !(gate_in && chain_in)) |=> $stable(q));

    // R6: terminal count requires chain enable
    p_tc_chain_r6: assert property (@(posedge clk)
        tc |-> (chain_in && (&q)));
endmodule

// File: rtl/sync_preset_counter.sv
module sync_preset_counter
    import cnt_pkg::*;
#(
    parameter int STAGES = 2,
    localparam int WIDTH = STAGES * DIGIT_W
) (
    input  logic             clk,
    input  logic             clear_n,
    input  logic             load_n,
    input  logic             gate_en,
    input  logic             chain_en,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] count,
    output logic             carry_out
);
    logic [STAGES:0] chain;

    assign chain[0] = chain_en;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        cnt_digit u_digit (
            .clk      (clk),
            .clear_n  (clear_n),
            .load_n   (load_n),
            .gate_in  (gate_en),
            .chain_in (chain[i]),
            .d        (din[i*DIGIT_W +: DIGIT_W]),
            .q        (count[i*DIGIT_W +: DIGIT_W]),
            .tc       (chain[i+1])
        );
    end

    assign carry_out = chain[STAGES];

    // R6: final carry is the chained decode of the full count
    p_carry_r6: assert property (@(posedge clk)
        carry_out == (chain_en && (&count)));

    // R7: full-width wrap through the lookahead chain
    p_wrap_r7: assert property (@(posedge clk) disable iff (!clear_n)
        (clear_n && load_n && gate_en && chain_en && (&count)) |=> (count == '0));

    // R4: full-width step across stage boundaries
    p_step_r4: assert property (@(posedge clk) disable iff (!clear_n)
        (clear_n && load_n && gate_en && chain_en) |=> (count == $past(count) + WIDTH'(1)));
endmodule

// File: tb/sync_preset_counter_bench.sv
`timescale 1ns/100ps
module sync_preset_counter_bench;
    localparam int STAGES = 2;
    localparam int W      = STAGES * 4;
    localparam int MOD    = 1 << W;

    logic         clk = 1'b0;
    logic         clear_n = 1'b0;
    logic         load_n = 1'b1;
    logic         gate_en = 1'b0;
    logic         chain_en = 1'b0;
    logic [W-1:0] din = '0;
    logic [W-1:0] count;
    logic         carry_out;

    int errors = 0;
    int checks = 0;
    int model  = 0;
    logic [15:0] lf = 16'hACE1;

    always #2.5 clk = ~clk;

    sync_preset_counter #(.STAGES(STAGES)) u_sync_preset_counter (
        .clk(clk), .clear_n(clear_n), .load_n(load_n), .gate_en(gate_en),
        .chain_en(chain_en), .din(din), .count(count), .carry_out(carry_out)
    );

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Drive one cycle: inputs set after a falling edge, result checked at next falling edge.
    task automatic step(logic c, logic l, logic g, logic t, int d);
        string tag;
        clear_n = c; load_n = l; gate_en = g; chain_en = t; din = W'(d);
        #1;
        chk("R1 count stable before edge", int'(count), model);
        chk("R6/R8 carry comb", int'(carry_out), (model == MOD-1 && t) ? 1 : 0);
        if (!c)          begin model = 0;                 tag = "R2 clear"; end
        else if (!l)     begin model = d % MOD;           tag = "R3 load";  end
        else if (g && t) begin model = (model + 1) % MOD; tag = "R4/R7 count"; end
        else             tag = "R5 hold";
        @(negedge clk);
        chk(tag, int'(count), model);
        chk("R6 carry after edge", int'(carry_out), (model == MOD-1 && t) ? 1 : 0);
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        model = 0;
        chk("R2 reset state", int'(count), 0);
        chk("R2 reset carry", int'(carry_out), 0);

        // full wrap-around, R4 R7
        for (int i = 0; i < MOD + 5; i++) step(1, 1, 1, 1, 0);

        // R3 load with enables low, then high
        step(1, 0, 0, 0, 8'h3C);
        step(1, 0, 1, 1, 8'hEF);
        // R4 step across digit boundary
        step(1, 1, 1, 1, 0);
        // R5 each enable alone
        step(1, 1, 0, 1, 0);
        step(1, 1, 1, 0, 0);
        step(1, 1, 0, 0, 0);
        // R2 clear beats load and enables
        step(1, 0, 0, 0, 8'h77);
        step(0, 0, 1, 1, 8'hAA);
        chk("R2 clear carry", int'(carry_out), 0);

        // R6 R8 carry at all ones, gate_en irrelevant, chain_en combinational
        step(1, 0, 0, 0, MOD-1);
        gate_en = 1'b0; chain_en = 1'b1; #1;
        chk("R6 carry with gate_en low", int'(carry_out), 1);
        chain_en = 1'b0; #1;
        chk("R8 carry follows chain_en", int'(carry_out), 0);
        chk("R1 no change without edge", int'(count), MOD-1);
        gate_en = 1'b1; #0.5;
        chk("R6 gate_en no carry", int'(carry_out), 0);
        @(negedge clk);
        chk("R5 hold chain low", int'(count), MOD-1);
        step(1, 1, 1, 1, 0);
        chk("R4 wrap to zero", int'(count), 0);

        // mixed pseudo-random controls
        for (int i = 0; i < 600; i++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            step(lf[3:0] != 4'd0, lf[7:5] != 3'd0, lf[8] | lf[9],
                 lf[10] | lf[11] | lf[12], int'(lf[15:8]));
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule